// File: doc/BRIEF.md
# Pseudo-Associative Cache Lookup

This block is a direct-mapped, write-back cache that gains a second chance on a miss. Every request first probes its home set. On a miss there, the block probes one partner set: the home index with its top bit inverted. A hit in the home set answers in one cycle. A hit in the partner set answers one cycle later and trades the two lines between the sets, so the next access to the same word is fast again. When both probes miss, the word is read from memory into the home set. The line that was in the home set moves to the partner set, and the partner's previous line is dropped. It is written to memory first if it holds modified data.

Each line stores a one-word block, a tag, a valid flag, a dirty flag and a displaced flag. The displaced flag marks a line that sits in the partner of its home set. Without it, a tag match in a set could be mistaken for a line that lives there. The CPU side takes one request at a time while `cpu_ready` is high. Each response carries exactly one of three latency flags: fast, slow or miss.

Top module: `pseudo_assoc_cache`

## Requirements
- R1: A request is accepted on a clock edge where `cpu_req` and `cpu_ready` are both high. The home set is `cpu_addr[IDX_W-1:0]` and the tag is the remaining upper bits. A hit there raises `rsp_valid` with `rsp_fast` one clock after acceptance.
- R2: After a home-set miss, the block probes the set whose index is the home index with bit IDX_W-1 inverted. A hit there raises `rsp_valid` with `rsp_slow` two clocks after acceptance and returns the stored word.
- R3: After a slow hit, the two sets exchange lines. A repeat access to the same word is a fast hit, and the line that was previously in the home set is then found with a slow hit.
- R4: A line held in the partner of its home set carries a displaced flag. Such a line never produces a hit for an address whose home is the set it currently occupies.
- R5: When both probes miss, the word is read from memory at its own address into the home set, and the response has `rsp_miss`. A read returns the memory word. The former home-set line moves to the partner set, where it is still found.
- R6: On a full miss with a valid home-set line, the partner set's former line is evicted. If that line is dirty, it is written to memory at its own address, with `mem_we` high, before the fill read is issued. A clean evicted line causes no memory write.
- R7: Writes are write-back. A write hit or a write miss updates the cache only, and memory keeps its old value until the line is evicted. A write miss allocates the line, and a later read returns the written word. For a write response, `rsp_rdata` echoes the written data.
- R8: Each response asserts exactly one of `rsp_fast`, `rsp_slow`, `rsp_miss`, and `rsp_valid` lasts one cycle. `cpu_ready` is low from acceptance until the response.
- R9: `mem_req` stays high with stable `mem_addr` and `mem_we` until a cycle in which `mem_ack` is high. On that edge a write completes, or a read takes `mem_rdata`.
- R10: On a full miss where the home set holds no valid line, the partner set is left untouched.
- R11: After reset all lines are invalid, `cpu_ready` is high, and `rsp_valid` and `mem_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_req | input | 1 | Request strobe |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Word address |
| cpu_wdata | input | DATA_W | Write data |
| cpu_ready | output | 1 | Block idle, request may be accepted |
| rsp_valid | output | 1 | Response strobe, one cycle |
| rsp_fast | output | 1 | Response came from the home set |
| rsp_slow | output | 1 | Response came from the partner set |
| rsp_miss | output | 1 | Response needed a memory fill |
| rsp_rdata | output | DATA_W | Read data, or echoed write data |
| mem_req | output | 1 | Memory transfer request |
| mem_we | output | 1 | 1 = write-back of a victim, 0 = fill read |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wdata | output | DATA_W | Victim data |
| mem_ack | input | 1 | Transfer completes on this cycle |
| mem_rdata | input | DATA_W | Fill data, valid with `mem_ack` |

## Verification
The bench uses addresses that share home set 0, whose partner is set 8, and one address whose home is set 8 with the same tag as a set-0 line. Repeated reads of one word separate fast hits from slow hits by latency. Alternating reads of two conflicting words show the exchange moving lines back and forth. The address homed in set 8 shows that a displaced line is not taken as a local hit. A dirty line is pushed out through two further conflicting misses. The order of memory operations shows that the write-back precedes the fill. A write miss, a memory check after writes, and a pair of partner sets starting empty cover allocation, write-back timing and the empty-home-set case.

// File: rtl/pacache_pkg.sv
// Package: shared state encoding and line layout constants for the
// pseudo-associative cache. A line vector is {valid, dirty, displaced, tag, data}.
package pacache_pkg;

    localparam int unsigned PA_FLAG_W = 3;

    typedef enum logic [2:0] {
        PA_IDLE,
        PA_PRIME,
        PA_ALT,
        PA_WBACK,
        PA_FILL
    } pa_state_e;

endpackage

// File: rtl/pacache_match.sv
// Module: pacache_match
// Tag comparator for one probe. It reports a hit when the stored line is
// valid, its tag equals the request tag, and its displaced flag equals the
// value this probe expects. Home probes expect 0 and partner probes expect 1.
// Assumes: purely combinational, no state.
module pacache_match #(
    parameter int unsigned TAG_W = 8
) (
    input  logic             line_valid,
    input  logic             line_moved,
    input  logic [TAG_W-1:0] line_tag,
    input  logic [TAG_W-1:0] req_tag,
    input  logic             want_moved,
    output logic             hit
);

    // compare validity, displacement and tag in one term
    always_comb begin
        hit = line_valid && (line_moved == want_moved) && (line_tag == req_tag);
    end

endmodule

// File: rtl/pacache_lines.sv
// Module: pacache_lines
// Line storage: one register per set, two combinational read ports and two
// write ports. Port A serves the home set and port B the partner set.
// Assumes: the controller never writes both ports to the same set in one cycle.
module pacache_lines #(
    parameter int unsigned IDX_W  = 4,
    parameter int unsigned LINE_W = 43
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  rd_a_idx,
    output logic [LINE_W-1:0] rd_a_line,
    input  logic [IDX_W-1:0]  rd_b_idx,
    output logic [LINE_W-1:0] rd_b_line,
    input  logic              wr_a_en,
    input  logic [IDX_W-1:0]  wr_a_idx,
    input  logic [LINE_W-1:0] wr_a_line,
    input  logic              wr_b_en,
    input  logic [IDX_W-1:0]  wr_b_idx,
    input  logic [LINE_W-1:0] wr_b_line
);

    localparam int unsigned SETS = 1 << IDX_W;

    logic [LINE_W-1:0] store [SETS];

    genvar s;
    generate
        for (s = 0; s < SETS; s++) begin : g_set
            // hold one line; cleared by reset, loaded by whichever port targets it
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    store[s] <= '0;
                end else if (wr_a_en && (wr_a_idx == IDX_W'(s))) begin
                    store[s] <= wr_a_line;
                end else if (wr_b_en && (wr_b_idx == IDX_W'(s))) begin
                    store[s] <= wr_b_line;
                end
            end
        end
    endgenerate

    // read both probe locations
    always_comb begin
        rd_a_line = store[rd_a_idx];
        rd_b_line = store[rd_b_idx];
    end

    // R3: an exchange writes two different sets, never one set twice
    a_r3_ports_disjoint: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_a_en && wr_b_en) |-> (wr_a_idx != wr_b_idx));

endmodule

// File: rtl/pseudo_assoc_cache.sv
// Module: pseudo_assoc_cache
// Direct-mapped write-back cache with a second probe into the partner set,
// whose index is the home index with its top bit inverted. A slow hit exchanges
// the two lines. A full miss fills the home set, moves the old home line to the
// partner set and evicts the partner's line, writing it back first if dirty.
// Assumes: one request outstanding; memory answers each request with a
// single-cycle mem_ack.
module pseudo_assoc_cache
    import pacache_pkg::*;
#(
    parameter int unsigned ADDR_W = 12,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned IDX_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic              cpu_ready,
    output logic              rsp_valid,
    output logic              rsp_fast,
    output logic              rsp_slow,
    output logic              rsp_miss,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata
);

    localparam int unsigned TAG_W  = ADDR_W - IDX_W;
    localparam int unsigned LINE_W = DATA_W + TAG_W + PA_FLAG_W;
    localparam int unsigned VB     = LINE_W - 1;
    localparam int unsigned DB     = LINE_W - 2;
    localparam int unsigned MB     = LINE_W - 3;
    localparam logic [IDX_W-1:0] ALT_FLIP = IDX_W'(1) << (IDX_W - 1);

    pa_state_e         state;
    logic              rq_we;
    logic [TAG_W-1:0]  rq_tag;
    logic [IDX_W-1:0]  rq_idx;
    logic [DATA_W-1:0] rq_wdata;

    logic [IDX_W-1:0]  prim_idx, alt_idx, victim_home;
    logic [LINE_W-1:0] prim_line, alt_line, prim_moved;
    logic              prim_hit, alt_hit, need_wb;
    logic [TAG_W-1:0]  prim_tag, alt_tag;
    logic [DATA_W-1:0] prim_data, alt_data;

    logic              wr_a_en, wr_b_en;
    logic [LINE_W-1:0] wr_a_line, wr_b_line;

    // derive probe indices and field views of the two probed lines
    always_comb begin
        prim_idx    = rq_idx;
        alt_idx     = rq_idx ^ ALT_FLIP;
        prim_tag    = prim_line[MB-1:DATA_W];
        prim_data   = prim_line[DATA_W-1:0];
        alt_tag     = alt_line[MB-1:DATA_W];
        alt_data    = alt_line[DATA_W-1:0];
        prim_moved  = {prim_line[VB:DB], ~prim_line[MB], prim_line[MB-1:0]};
        victim_home = alt_line[MB] ? prim_idx : alt_idx;
        need_wb     = prim_line[VB] && alt_line[VB] && alt_line[DB];
    end

    pacache_lines #(
        .IDX_W  (IDX_W),
        .LINE_W (LINE_W)
    ) i_lines (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_a_idx  (prim_idx),
        .rd_a_line (prim_line),
        .rd_b_idx  (alt_idx),
        .rd_b_line (alt_line),
        .wr_a_en   (wr_a_en),
        .wr_a_idx  (prim_idx),
        .wr_a_line (wr_a_line),
        .wr_b_en   (wr_b_en),
        .wr_b_idx  (alt_idx),
        .wr_b_line (wr_b_line)
    );

    pacache_match #(.TAG_W(TAG_W)) i_match_home (
        .line_valid (prim_line[VB]),
        .line_moved (prim_line[MB]),
        .line_tag   (prim_tag),
        .req_tag    (rq_tag),
        .want_moved (1'b0),
        .hit        (prim_hit)
    );

    pacache_match #(.TAG_W(TAG_W)) i_match_alt (
        .line_valid (alt_line[VB]),
        .line_moved (alt_line[MB]),
        .line_tag   (alt_tag),
        .req_tag    (rq_tag),
        .want_moved (1'b1),
        .hit        (alt_hit)
    );

    // choose line updates: write hit, exchange on slow hit, install on fill
    always_comb begin
        wr_a_en   = 1'b0;
        wr_a_line = '0;
        wr_b_en   = 1'b0;
        wr_b_line = '0;
        case (state)
            PA_PRIME: begin
                if (prim_hit && rq_we) begin
                    wr_a_en   = 1'b1;
                    wr_a_line = {1'b1, 1'b1, 1'b0, rq_tag, rq_wdata};
                end
            end
            PA_ALT: begin
                if (alt_hit) begin
                    wr_a_en   = 1'b1;
                    wr_a_line = {1'b1, alt_line[DB] | rq_we, 1'b0, alt_tag,
                                 rq_we ? rq_wdata : alt_data};
                    wr_b_en   = 1'b1;
                    wr_b_line = prim_moved;
                end
            end
            PA_FILL: begin
                if (mem_ack) begin
                    wr_a_en   = 1'b1;
                    wr_a_line = {1'b1, rq_we, 1'b0, rq_tag,
                                 rq_we ? rq_wdata : mem_rdata};
                    wr_b_en   = prim_line[VB];
                    wr_b_line = prim_moved;
                end
            end
            default: ;
        endcase
    end

    // sequence probes, write-back and fill; register the response
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= PA_IDLE;
            rq_we     <= 1'b0;
            rq_tag    <= '0;
            rq_idx    <= '0;
            rq_wdata  <= '0;
            rsp_valid <= 1'b0;
            rsp_fast  <= 1'b0;
            rsp_slow  <= 1'b0;
            rsp_miss  <= 1'b0;
            rsp_rdata <= '0;
            mem_req   <= 1'b0;
            mem_we    <= 1'b0;
            mem_addr  <= '0;
            mem_wdata <= '0;
        end else begin
            rsp_valid <= 1'b0;
            rsp_fast  <= 1'b0;
            rsp_slow  <= 1'b0;
            rsp_miss  <= 1'b0;
            case (state)
                PA_IDLE: begin
                    if (cpu_req) begin
                        rq_we    <= cpu_we;
                        rq_tag   <= cpu_addr[ADDR_W-1:IDX_W];
                        rq_idx   <= cpu_addr[IDX_W-1:0];
                        rq_wdata <= cpu_wdata;
                        state    <= PA_PRIME;
                    end
                end
                PA_PRIME: begin
                    if (prim_hit) begin
                        rsp_valid <= 1'b1;
                        rsp_fast  <= 1'b1;
                        rsp_rdata <= rq_we ? rq_wdata : prim_data;
                        state     <= PA_IDLE;
                    end else begin
                        state     <= PA_ALT;
                    end
                end
                PA_ALT: begin
                    if (alt_hit) begin
                        rsp_valid <= 1'b1;
                        rsp_slow  <= 1'b1;
                        rsp_rdata <= rq_we ? rq_wdata : alt_data;
                        state     <= PA_IDLE;
                    end else if (need_wb) begin
                        mem_req   <= 1'b1;
                        mem_we    <= 1'b1;
                        mem_addr  <= {alt_tag, victim_home};
                        mem_wdata <= alt_data;
                        state     <= PA_WBACK;
                    end else begin
                        mem_req   <= 1'b1;
                        mem_we    <= 1'b0;
                        mem_addr  <= {rq_tag, rq_idx};
                        state     <= PA_FILL;
                    end
                end
                PA_WBACK: begin
                    if (mem_ack) begin
                        mem_we   <= 1'b0;
                        mem_addr <= {rq_tag, rq_idx};
                        state    <= PA_FILL;
                    end
                end
                PA_FILL: begin
                    if (mem_ack) begin
                        mem_req   <= 1'b0;
                        rsp_valid <= 1'b1;
                        rsp_miss  <= 1'b1;
                        rsp_rdata <= rq_we ? rq_wdata : mem_rdata;
                        state     <= PA_IDLE;
                    end
                end
                default: state <= PA_IDLE;
            endcase
        end
    end

    // accept requests only while idle
    always_comb begin
        cpu_ready = (state == PA_IDLE);
    end

    // R1: a home-set hit answers on the next edge as fast
    a_r1_fast_next: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PA_PRIME && prim_hit) |=> (rsp_valid && rsp_fast));

    // R2: a partner-set hit answers on the next edge as slow
    a_r2_slow_next: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PA_ALT && alt_hit) |=> (rsp_valid && rsp_slow));

    // R4: a probe never reports both locations at once for one request
    a_r4_single_location: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PA_ALT) |-> !prim_hit);

    // R6: an acknowledged write-back is followed directly by the fill read
    a_r6_wb_then_fill: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && mem_ack) |=> (mem_req && !mem_we));

    // R8: exactly one latency flag with each response
    a_r8_one_flag: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $onehot({rsp_fast, rsp_slow, rsp_miss}));

    // R8: no latency flag without a response
    a_r8_flags_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> !(rsp_fast || rsp_slow || rsp_miss));

    // R9: an unanswered memory request holds its address and direction
    a_r9_mem_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

endmodule

// File: tb/test_pseudo_assoc_cache.sv
module test_pseudo_assoc_cache;

    localparam int unsigned ADDR_W = 12;
    localparam int unsigned DATA_W = 32;
    localparam int unsigned IDX_W  = 4;
    localparam int K_FAST = 1;
    localparam int K_SLOW = 2;
    localparam int K_MISS = 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cpu_req = 1'b0;
    logic              cpu_we = 1'b0;
    logic [ADDR_W-1:0] cpu_addr = '0;
    logic [DATA_W-1:0] cpu_wdata = '0;
    logic              cpu_ready, rsp_valid, rsp_fast, rsp_slow, rsp_miss;
    logic [DATA_W-1:0] rsp_rdata;
    logic              mem_req, mem_we;
    logic [ADDR_W-1:0] mem_addr;
    logic [DATA_W-1:0] mem_wdata;
    logic              mem_ack = 1'b0;
    logic [DATA_W-1:0] mem_rdata = '0;

    int n_checks = 0;
    int n_fail   = 0;
    logic [DATA_W-1:0] mem [1 << ADDR_W];
    int hs_err = 0, op_no = 0, wb_cnt = 0, wb_op = 0, fill_op = 0;
    logic [ADDR_W-1:0] wb_addr = '0;
    logic [DATA_W-1:0] wb_data = '0;

    pseudo_assoc_cache #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) i_pseudo_assoc_cache (
        .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_ready(cpu_ready),
        .rsp_valid(rsp_valid), .rsp_fast(rsp_fast), .rsp_slow(rsp_slow),
        .rsp_miss(rsp_miss), .rsp_rdata(rsp_rdata), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata));

    always #10 clk = ~clk;

    function automatic logic [DATA_W-1:0] init_word(input int a);
        return 32'hA000_0000 | DATA_W'(a);
    endfunction

    task automatic check(input string req, input longint act, input longint exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // memory model: two-cycle answer, records write-backs and fill order
    initial begin
        for (int a = 0; a < (1 << ADDR_W); a++) mem[a] = init_word(a);
        forever begin
            @(negedge clk);
            if (mem_req) begin
                logic [ADDR_W-1:0] a;
                logic w;
                a = mem_addr;
                w = mem_we;
                repeat (2) begin
                    @(negedge clk);
                    if (mem_addr != a || mem_we != w || !mem_req) hs_err++;
                end
                op_no++;
                if (w) begin
                    mem[a] = mem_wdata;
                    wb_cnt++;
                    wb_addr = a;
                    wb_data = mem_wdata;
                    wb_op = op_no;
                end else begin
                    mem_rdata = mem[a];
                    fill_op = op_no;
                end
                mem_ack = 1'b1;
                @(negedge clk);
                mem_ack = 1'b0;
            end
        end
    end

    // one CPU access; returns latency class, data and cycles to the response
    task automatic access(input logic we, input int addr, input logic [DATA_W-1:0] wd,
                          output int kind, output logic [DATA_W-1:0] rd, output int lat);
        @(negedge clk);
        while (!cpu_ready) @(negedge clk);
        cpu_req = 1'b1; cpu_we = we; cpu_addr = ADDR_W'(addr); cpu_wdata = wd;
        @(negedge clk);
        cpu_req = 1'b0;
        check("R8 ready low while busy", cpu_ready, 0);
        lat = 0;
        while (!rsp_valid) begin
            @(negedge clk);
            lat++;
        end
        check("R8 one flag", int'(rsp_fast) + int'(rsp_slow) + int'(rsp_miss), 1);
        kind = rsp_fast ? K_FAST : rsp_slow ? K_SLOW : rsp_miss ? K_MISS : 0;
        rd = rsp_rdata;
        @(negedge clk);
        check("R8 single-cycle response", rsp_valid, 0);
    endtask

    task automatic expect_read(input string req, input int addr, input int k_exp,
                               input logic [DATA_W-1:0] d_exp);
        int k, l;
        logic [DATA_W-1:0] d;
        access(1'b0, addr, '0, k, d, l);
        check(req, k, k_exp);
        check(req, d, d_exp);
        if (k_exp == K_FAST) check(req, l, 1);
        if (k_exp == K_SLOW) check(req, l, 2);
    endtask

    task automatic t_reset();
        check("R11 ready after reset", cpu_ready, 1);
        check("R11 no response after reset", rsp_valid, 0);
        check("R11 no memory request after reset", mem_req, 0);
    endtask

    task automatic t_basic();
        expect_read("R11 cold read misses", 12'h010, K_MISS, init_word(12'h010));
        expect_read("R1 repeat read is fast", 12'h010, K_FAST, init_word(12'h010));
    endtask

    task automatic t_conflict();
        expect_read("R5 conflicting fill", 12'h020, K_MISS, init_word(12'h020));
        expect_read("R2 displaced line slow hit", 12'h010, K_SLOW, init_word(12'h010));
        expect_read("R3 after exchange fast", 12'h010, K_FAST, init_word(12'h010));
        expect_read("R3 other line now slow", 12'h020, K_SLOW, init_word(12'h020));
    endtask

    task automatic t_displaced_flag();
        int wb0;
        wb0 = wb_cnt;
        expect_read("R4 same tag in partner set misses", 12'h018, K_MISS, init_word(12'h018));
        expect_read("R5 moved line home is fast", 12'h010, K_FAST, init_word(12'h010));
        expect_read("R6 partner line was evicted", 12'h020, K_MISS, init_word(12'h020));
        check("R6 clean evictions write nothing", wb_cnt, wb0);
    endtask

    task automatic t_writeback();
        int k, l, wb0;
        logic [DATA_W-1:0] d;
        access(1'b1, 12'h010, 32'h1234_5678, k, d, l);
        check("R7 write slow hit", k, K_SLOW);
        check("R7 write echo", d, 32'h1234_5678);
        check("R7 memory untouched by write hit", mem[12'h010], init_word(12'h010));
        expect_read("R7 written word read back", 12'h010, K_FAST, 32'h1234_5678);
        wb0 = wb_cnt;
        expect_read("R6 push dirty line to partner", 12'h030, K_MISS, init_word(12'h030));
        check("R6 no write-back yet", wb_cnt, wb0);
        expect_read("R6 evicting miss", 12'h040, K_MISS, init_word(12'h040));
        check("R6 one write-back", wb_cnt, wb0 + 1);
        check("R6 write-back address", wb_addr, 12'h010);
        check("R6 write-back data", wb_data, 32'h1234_5678);
        check("R6 write-back before fill", wb_op, fill_op - 1);
        expect_read("R6 refetched dirty data", 12'h010, K_MISS, 32'h1234_5678);
    endtask

    task automatic t_write_miss();
        int k, l;
        logic [DATA_W-1:0] d;
        access(1'b1, 12'h105, 32'hCAFE_0105, k, d, l);
        check("R7 write miss", k, K_MISS);
        check("R7 memory untouched by write miss", mem[12'h105], init_word(12'h105));
        expect_read("R7 write miss allocated", 12'h105, K_FAST, 32'hCAFE_0105);
    endtask

    task automatic t_empty_home();
        int wb0;
        wb0 = wb_cnt;
        expect_read("R10 fill set 11", 12'h00B, K_MISS, init_word(12'h00B));
        expect_read("R10 fill empty set 3", 12'h003, K_MISS, init_word(12'h003));
        expect_read("R10 partner line kept", 12'h00B, K_FAST, init_word(12'h00B));
        expect_read("R10 new line in home set", 12'h003, K_FAST, init_word(12'h003));
        check("R10 no write-back", wb_cnt, wb0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_conflict();
        t_displaced_flag();
        t_writeback();
        t_write_miss();
        t_empty_home();
        check("R9 memory request held until acknowledged", hs_err, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule